// File: doc/BRIEF.md
# Set-Associative Translation Buffer

This block keeps recently used translation entries for a 32-bit virtual address space built from 4 KB pages. It has 16 sets of 4 ways, for 64 entries in all. Each entry stores a valid flag, a kind flag, a 16-bit tag and the full 32-bit entry word. The kind flag is 1 when the entry is a directory-level entry and 0 when it is a leaf page entry.

A requester presents a virtual address and the kind of entry it wants. One cycle later the block answers with hit or miss. On a hit it also returns the physical address and the cached entry word, so the flag bits can be checked elsewhere. On a miss, an external walker fetches the leaf entry from memory, and the directory entry as well if that one is missing too. The walker then writes each entry back through the fill port.

Two flush inputs are provided. The task-switch flush keeps global entries. The full flush clears everything.

Top module: `tlb_set_assoc`

## Requirements
- R1: After reset every entry is invalid and `rsp_valid` is low, so any lookup made before the first fill misses.
- R2: `rsp_valid` rises exactly one cycle after a cycle with `lk_valid` high. The set is taken from address bits 15:12 and the tag from bits 31:16. An entry filled under one set or tag does not answer a lookup that differs in either.
- R3: On a hit, `rsp_paddr` equals bits 31:12 of the cached entry word followed by lookup address bits 11:0, and `rsp_word` equals the whole entry word. On a miss, `rsp_hit`, `rsp_paddr` and `rsp_word` are all zero.
- R4: An entry hits only when its kind flag equals `lk_dir`. A directory entry and a leaf entry with the same address live side by side.
- R5: A fill goes to the lowest-numbered invalid way of its set, so four distinct tags in one set all stay resident.
- R6: When all four ways of a set are valid, a per-set 2-bit round-robin pointer picks the victim. The pointer starts at way 0 after reset and advances by one after each eviction.
- R7: A fill whose tag and kind match a valid entry in the set overwrites that way in place. It never creates a second copy and does not advance the pointer.
- R8: A cycle with `flush_task` high invalidates every entry whose entry-word bit 8 (global) is 0 and keeps the entries where that bit is 1.
- R9: A cycle with `flush_all` high invalidates every entry, global ones included.
- R10: A lookup in the same cycle as a fill to the same set is answered as a miss, and the fill takes effect. A lookup to a different set in that cycle is answered normally.
- R11: A fill in the same cycle as a flush survives the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_dir | input | 1 | Kind wanted: 1 directory entry, 0 leaf entry |
| fill_valid | input | 1 | Fill request from the walker |
| fill_vaddr | input | 32 | Virtual address the filled entry translates |
| fill_dir | input | 1 | Kind of the filled entry |
| fill_word | input | 32 | Entry word to store |
| flush_task | input | 1 | Invalidate all non-global entries |
| flush_all | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 32 | Physical address on hit, zero on miss |
| rsp_word | output | 32 | Cached entry word on hit, zero on miss |

## Verification
The bench fills one set beyond its capacity twice. A pointer that never advances, or that ignores invalid ways, would evict the wrong tag. It refills an existing tag and then overflows the set, so a design that stored a duplicate would lose the directory entry that should have survived. It runs a task flush over a mix of global and non-global entries. It also drives a fill together with a same-set lookup, and a fill together with a flush. A design that read stale contents during the collision, or let the flush win over the fill, would report the wrong hit state.

// File: rtl/tlb_set_assoc.sv
module tlb_set_assoc #(
  parameter int VA_W    = 32,
  parameter int PG_W    = 12,
  parameter int SET_W   = 4,
  parameter int WAY_W   = 2,
  parameter int GLB_BIT = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic            lk_dir,
  input  logic            fill_valid,
  input  logic [VA_W-1:0] fill_vaddr,
  input  logic            fill_dir,
  input  logic [VA_W-1:0] fill_word,
  input  logic            flush_task,
  input  logic            flush_all,
  output logic            rsp_valid,
  output logic            rsp_hit,
  output logic [VA_W-1:0] rsp_paddr,
  output logic [VA_W-1:0] rsp_word
);
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 1 << WAY_W;
  localparam int ENT   = SETS * WAYS;
  localparam int IDX_W = SET_W + WAY_W;
  localparam int TAG_W = VA_W - PG_W - SET_W;

  logic [ENT-1:0]   v_q, pd_q;
  logic [TAG_W-1:0] tag_q  [ENT];
  logic [VA_W-1:0]  word_q [ENT];
  logic [WAY_W-1:0] rr_q   [SETS];

  logic [SET_W-1:0] lk_set, fl_set;
  logic [TAG_W-1:0] lk_tag, fl_tag;
  assign lk_set = lk_vaddr[PG_W +: SET_W];
  assign lk_tag = lk_vaddr[VA_W-1 -: TAG_W];
  assign fl_set = fill_vaddr[PG_W +: SET_W];
  assign fl_tag = fill_vaddr[VA_W-1 -: TAG_W];

  logic [WAYS-1:0] lk_hitv, fl_match, fl_inv;
  logic [VA_W-1:0] lk_word;
  always_comb begin
    lk_word = '0;
    for (int w = 0; w < WAYS; w++) begin
      lk_hitv[w]  = v_q[{lk_set, WAY_W'(w)}] && (pd_q[{lk_set, WAY_W'(w)}] == lk_dir)
                    && (tag_q[{lk_set, WAY_W'(w)}] == lk_tag);
      fl_match[w] = v_q[{fl_set, WAY_W'(w)}] && (pd_q[{fl_set, WAY_W'(w)}] == fill_dir)
                    && (tag_q[{fl_set, WAY_W'(w)}] == fl_tag);
      fl_inv[w]   = !v_q[{fl_set, WAY_W'(w)}];
      if (lk_hitv[w]) lk_word = lk_word | word_q[{lk_set, WAY_W'(w)}];
    end
  end

  logic [WAY_W-1:0] fl_way;
  logic             fl_evict;
  always_comb begin
    logic found;
    found    = 1'b0;
    fl_way   = rr_q[fl_set];
    fl_evict = 1'b1;
    for (int w = 0; w < WAYS; w++)
      if (!found && fl_match[w]) begin
        found = 1'b1; fl_way = WAY_W'(w); fl_evict = 1'b0;
      end
    for (int w = 0; w < WAYS; w++)
      if (!found && fl_inv[w]) begin
        found = 1'b1; fl_way = WAY_W'(w); fl_evict = 1'b0;
      end
  end

  logic [IDX_W-1:0] fl_idx;
  logic             collide, lk_hit;
  assign fl_idx  = {fl_set, fl_way};
  assign collide = fill_valid && (fl_set == lk_set);
  assign lk_hit  = (|lk_hitv) && !collide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q       <= '0;
      pd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_paddr <= '0;
      rsp_word  <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_hit   <= lk_hit;
        rsp_paddr <= lk_hit ? {lk_word[VA_W-1:PG_W], lk_vaddr[PG_W-1:0]} : '0;
        rsp_word  <= lk_hit ? lk_word : '0;
      end else begin
        rsp_hit   <= 1'b0;
        rsp_paddr <= '0;
        rsp_word  <= '0;
      end
      if (flush_all)
        v_q <= '0;
      else if (flush_task)
        for (int e = 0; e < ENT; e++)
          if (!word_q[e][GLB_BIT]) v_q[e] <= 1'b0;
      if (fill_valid) begin
        v_q[fl_idx]    <= 1'b1;
        pd_q[fl_idx]   <= fill_dir;
        tag_q[fl_idx]  <= fl_tag;
        word_q[fl_idx] <= fill_word;
        if (fl_evict) rr_q[fl_set] <= rr_q[fl_set] + 1'b1;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && rsp_word == '0)); // R3
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (!rsp_hit || rsp_paddr[PG_W-1:0] == $past(lk_vaddr[PG_W-1:0]))); // R3
  AST_NO_DUPLICATE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hitv)); // R7
  AST_FULL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_valid) |=> (v_q == '0)); // R9
  AST_COLLIDE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && fill_valid && lk_vaddr[PG_W +: SET_W] == fill_vaddr[PG_W +: SET_W])
    |=> !rsp_hit); // R10
endmodule

// File: tb/tb_tlb_set_assoc.sv
module tb_tlb_set_assoc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_dir = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        fill_valid = 1'b0, fill_dir = 1'b0;
  logic [31:0] fill_vaddr = '0, fill_word = '0;
  logic        flush_task = 1'b0, flush_all = 1'b0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_paddr, rsp_word;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_set_assoc dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_dir(lk_dir),
    .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_dir(fill_dir), .fill_word(fill_word),
    .flush_task(flush_task), .flush_all(flush_all),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_word(rsp_word)
  );

  function automatic logic [31:0] va(input int tag, input int set, input logic [11:0] off);
    return {16'(tag), 4'(set), off};
  endfunction

  function automatic logic [31:0] wd(input int tag, input int set, input logic [11:0] fl);
    return {12'h0, 4'(set), 4'(tag), fl};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic [31:0] a, input logic d, input logic [31:0] w);
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = a; fill_dir = d; fill_word = w;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] a, input logic d, input bit eh,
                      input logic [31:0] ew, input string rq);
    logic [31:0] ep;
    ep = eh ? {ew[31:12], a[11:0]} : 32'h0;
    @(negedge clk);
    lk_valid = 1'b1; lk_vaddr = a; lk_dir = d;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(rsp_valid && rsp_hit == eh && rsp_paddr == ep && rsp_word == (eh ? ew : 32'h0), rq,
        {rsp_hit, 31'(rsp_paddr[30:0]), rsp_word}, {eh, 31'(ep[30:0]), eh ? ew : 32'h0});
  endtask

  task automatic t_reset;
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    look(va(1, 3, 12'h123), 1'b0, 0, 0, "R1 empty after reset");
    look(va(0, 0, 12'h000), 1'b1, 0, 0, "R1 empty dir after reset");
  endtask

  task automatic t_hit_kind;
    fill(va(1, 3, 0), 1'b0, 32'hABCDE067);
    look(va(1, 3, 12'hABC), 1'b0, 1, 32'hABCDE067, "R3 leaf hit paddr");
    look(va(1, 3, 12'h001), 1'b0, 1, 32'hABCDE067, "R3 offset passes");
    look(va(1, 3, 12'hABC), 1'b1, 0, 0, "R4 kind mismatch misses");
    fill(va(1, 3, 0), 1'b1, 32'h11111001);
    look(va(1, 3, 12'hABC), 1'b1, 1, 32'h11111001, "R4 dir entry hit");
    look(va(1, 3, 12'hABC), 1'b0, 1, 32'hABCDE067, "R4 leaf kept beside dir");
    look(va(1, 4, 12'hABC), 1'b0, 0, 0, "R2 other set misses");
    look(va(2, 3, 12'hABC), 1'b0, 0, 0, "R2 other tag misses");
  endtask

  task automatic t_replace;
    for (int t = 1; t <= 4; t++) fill(va(t, 5, 0), 1'b0, wd(t, 5, 12'h001));
    for (int t = 1; t <= 4; t++) look(va(t, 5, 12'h010), 1'b0, 1, wd(t, 5, 12'h001), "R5 four ways resident");
    fill(va(5, 5, 0), 1'b0, wd(5, 5, 12'h001));
    look(va(1, 5, 12'h010), 1'b0, 0, 0, "R6 first eviction takes way 0");
    for (int t = 2; t <= 5; t++) look(va(t, 5, 12'h010), 1'b0, 1, wd(t, 5, 12'h001), "R6 survivors after eviction 1");
    fill(va(6, 5, 0), 1'b0, wd(6, 5, 12'h001));
    look(va(2, 5, 12'h010), 1'b0, 0, 0, "R6 second eviction takes way 1");
    look(va(3, 5, 12'h010), 1'b0, 1, wd(3, 5, 12'h001), "R6 way 2 kept");
    look(va(6, 5, 12'h010), 1'b0, 1, wd(6, 5, 12'h001), "R6 newest present");
  endtask

  task automatic t_refill;
    fill(va(1, 3, 0), 1'b0, 32'h22222003);
    look(va(1, 3, 12'h00F), 1'b0, 1, 32'h22222003, "R7 refill overwrites");
    fill(va(7, 3, 0), 1'b0, wd(7, 3, 12'h001));
    fill(va(8, 3, 0), 1'b0, wd(8, 3, 12'h001));
    fill(va(9, 3, 0), 1'b0, wd(9, 3, 12'h001));
    look(va(1, 3, 12'h00F), 1'b1, 1, 32'h11111001, "R7 dir entry survives no duplicate");
    look(va(1, 3, 12'h00F), 1'b0, 0, 0, "R7 refilled way evicted by pointer");
    look(va(7, 3, 12'h00F), 1'b0, 1, wd(7, 3, 12'h001), "R7 way 2 resident");
    look(va(9, 3, 12'h00F), 1'b0, 1, wd(9, 3, 12'h001), "R7 new fill resident");
  endtask

  task automatic t_task_flush;
    fill(va(1, 6, 0), 1'b0, 32'h33333100);
    fill(va(2, 6, 0), 1'b0, 32'h44444000);
    @(negedge clk); flush_task = 1'b1;
    @(negedge clk); flush_task = 1'b0;
    look(va(1, 6, 12'h044), 1'b0, 1, 32'h33333100, "R8 global entry kept");
    look(va(2, 6, 12'h044), 1'b0, 0, 0, "R8 non-global dropped");
    look(va(3, 5, 12'h044), 1'b0, 0, 0, "R8 non-global other set dropped");
  endtask

  task automatic t_full_flush;
    @(negedge clk); flush_all = 1'b1;
    @(negedge clk); flush_all = 1'b0;
    look(va(1, 6, 12'h044), 1'b0, 0, 0, "R9 global entry dropped");
    look(va(1, 3, 12'h044), 1'b1, 0, 0, "R9 dir entry dropped");
  endtask

  task automatic t_collide;
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = va(1, 7, 0); fill_dir = 1'b0; fill_word = wd(1, 7, 12'h001);
    lk_valid = 1'b1; lk_vaddr = va(1, 7, 12'h055); lk_dir = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk(rsp_valid && !rsp_hit && rsp_paddr == 0, "R10 same-set lookup misses", 64'(rsp_hit), 64'd0);
    look(va(1, 7, 12'h055), 1'b0, 1, wd(1, 7, 12'h001), "R10 fill took effect");
    fill(va(1, 8, 0), 1'b0, wd(1, 8, 12'h001));
    @(negedge clk);
    fill_valid = 1'b1; fill_vaddr = va(2, 7, 0); fill_dir = 1'b0; fill_word = wd(2, 7, 12'h001);
    lk_valid = 1'b1; lk_vaddr = va(1, 8, 12'h066); lk_dir = 1'b0;
    @(negedge clk);
    fill_valid = 1'b0; lk_valid = 1'b0;
    chk(rsp_valid && rsp_hit && rsp_paddr == {wd(1, 8, 0) >> 12, 12'h066} >> 0,
        "R10 other-set lookup hits", 64'(rsp_paddr), 64'({wd(1, 8, 0)[31:12], 12'h066}));
  endtask

  task automatic t_flush_fill;
    @(negedge clk);
    flush_all = 1'b1;
    fill_valid = 1'b1; fill_vaddr = va(1, 9, 0); fill_dir = 1'b0; fill_word = wd(1, 9, 12'h001);
    @(negedge clk);
    flush_all = 1'b0; fill_valid = 1'b0;
    look(va(1, 9, 12'h077), 1'b0, 1, wd(1, 9, 12'h001), "R11 fill survives full flush");
    look(va(1, 7, 12'h077), 1'b0, 0, 0, "R11 older entries flushed");
    @(negedge clk);
    flush_task = 1'b1;
    fill_valid = 1'b1; fill_vaddr = va(2, 9, 0); fill_dir = 1'b0; fill_word = wd(2, 9, 12'h000);
    @(negedge clk);
    flush_task = 1'b0; fill_valid = 1'b0;
    look(va(2, 9, 12'h077), 1'b0, 1, wd(2, 9, 12'h000), "R11 fill survives task flush");
    look(va(1, 9, 12'h077), 1'b0, 0, 0, "R8 non-global dropped beside fill");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit_kind();
    t_replace();
    t_refill();
    t_task_flush();
    t_full_flush();
    t_collide();
    t_flush_fill();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule